// File: doc/BRIEF.md
# Double-Buffered Bulk Endpoint Flow Controller

This block runs the flow control of one bulk endpoint that works in a single direction and owns two packet buffers. A data-toggle bit, taken from whichever direction is enabled, tells the bus engine which buffer to use. The bit flips after every transaction that completes, so the engine alternates between buffer 0 and buffer 1. While the engine works on one buffer, application software works on the other.

The toggle bit of the disabled direction has a second use: it is a software buffer flag that names the buffer software currently holds. The endpoint drops to NAK only when the engine's next buffer is the one software still holds. It does not drop to NAK after every completed transaction. When software releases its buffer by flipping the flag, the endpoint returns to VALID on its own.

The bus engine offers one transaction at a time on a valid/ready event port and gets a handshake choice back on a valid/ready response port. An event is accepted only when the response register is free or being drained in the same cycle, and only in a cycle with no control-word write. A response stays valid, with its code held, until `hs_ready` is seen high. Software uses a plain control-word write port and a plain descriptor port. The descriptor table has four entries: entry 0 is the buffer 0 address, entry 1 the buffer 0 length, entry 2 the buffer 1 address and entry 3 the buffer 1 length.

Top module: `dbuf_ep_ctrl`

## Requirements
- R1: After reset, the control word reads 0, `hs_valid` is 0, `evt_ready` is 1 and all descriptor entries are 0.
- R2: The receive status field (bits 13:12) and the transmit status field (bits 5:4) change by write-1-to-flip. The codes are 00 disabled, 01 stall, 10 NAK and 11 VALID. A write that would leave both fields non-zero leaves both fields unchanged.
- R3: The receive toggle (bit 14) and the transmit toggle (bit 6) flip when a 1 is written to them and are unchanged by a 0. The engine toggle is the toggle of the direction whose status is non-zero (the receive toggle when neither is). The other toggle is the software buffer flag.
- R4: An accepted event returns a handshake code (0 none, 1 ACK, 2 NAK, 3 stall) set by the active status. Disabled gives 0, stall gives 3 and NAK gives 2. VALID gives 1 on success and 0 on failure. A failed event changes no control-word bit.
- R5: A successful event under VALID flips the engine toggle. If the new engine toggle equals the software buffer flag, the active status becomes NAK; otherwise it stays VALID.
- R6: A write that flips the software buffer flag while the active status is NAK, and leaves the two toggles different, sets the active status to VALID.
- R7: `buf_addr` and `buf_len` show descriptor entries 2·t and 2·t+1, where t is the engine toggle.
- R8: A successful receive event writes the zero-extended `evt_count` into entry 2·t+1, with t taken before the flip. A successful transmit event writes no entry.
- R9: `evt_ready` is low while `reg_wr_en` is high or while a response is held with `hs_ready` low. A response appears on `hs_valid` in the cycle after acceptance and keeps its code until it is taken.
- R10: A descriptor write stores `desc_wdata` in entry `desc_idx`. `desc_rdata` shows that entry at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr_en | input | 1 | Control-word write strobe |
| reg_wdata | input | 16 | Control-word write data (flip masks) |
| reg_rdata | output | 16 | Control-word read value |
| desc_wr_en | input | 1 | Descriptor write strobe |
| desc_idx | input | 2 | Descriptor entry index |
| desc_wdata | input | DESC_W | Descriptor write data |
| desc_rdata | output | DESC_W | Descriptor entry at `desc_idx` |
| buf_addr | output | DESC_W | Address of the engine's current buffer |
| buf_len | output | DESC_W | Length of the engine's current buffer |
| evt_valid | input | 1 | Transaction event offered |
| evt_ready | output | 1 | Transaction event accepted this cycle |
| evt_ok | input | 1 | Transaction succeeded |
| evt_count | input | CNT_W | Received byte count |
| hs_valid | output | 1 | Handshake choice available |
| hs_ready | input | 1 | Handshake choice taken |
| hs_code | output | 2 | Handshake choice |

## Verification
The bench runs the receive endpoint through a full collision cycle. The first completed transaction must stay VALID and the second must fall to NAK. A design that compares toggles before the flip would stop one transaction early, and one that always NAKs would fail on the first check. A failed event under VALID and any event under NAK must leave the toggles alone, or the two buffers lose their alternation. Toggle writes that try to enable the second direction must be refused, and a transmit success must not overwrite a length entry that a receive path would write. Holding `hs_ready` low must block the next event; a design that drops the stall would overwrite the held ACK with a NAK.

// File: rtl/dbuf_ep_pkg.sv
package dbuf_ep_pkg;
  localparam int CW_W        = 16;
  localparam int RX_TOG_BIT  = 14;
  localparam int RX_STAT_LSB = 12;
  localparam int TX_TOG_BIT  = 6;
  localparam int TX_STAT_LSB = 4;
  localparam int N_DESC      = 4;
  localparam int DESC_IDX_W  = $clog2(N_DESC);

  localparam logic [1:0] ST_OFF   = 2'b00;
  localparam logic [1:0] ST_STALL = 2'b01;
  localparam logic [1:0] ST_NAK   = 2'b10;
  localparam logic [1:0] ST_VALID = 2'b11;

  localparam logic [1:0] HS_NONE  = 2'd0;
  localparam logic [1:0] HS_ACK   = 2'd1;
  localparam logic [1:0] HS_NAK   = 2'd2;
  localparam logic [1:0] HS_STALL = 2'd3;

  typedef struct packed {
    logic       rx_tog;
    logic [1:0] rx_stat;
    logic       tx_tog;
    logic [1:0] tx_stat;
  } ep_ctl_t;
endpackage

// File: rtl/dbuf_ep_ctlreg.sv
module dbuf_ep_ctlreg
  import dbuf_ep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  ep_ctl_t    wr_mask,
  input  logic       txn_fire,
  input  logic       txn_ok,
  output ep_ctl_t    ctl,
  output logic       eng_tog,
  output logic       rx_mode,
  output logic [1:0] txn_hs,
  output logic       txn_done
);
  logic       tx_act;
  logic [1:0] cur_stat;
  ep_ctl_t    nxt;
  logic [1:0] cand_rx, cand_tx;
  logic       n_tx_act, sw_flip;

  assign tx_act   = (ctl.tx_stat != ST_OFF);
  assign rx_mode  = (ctl.rx_stat != ST_OFF);
  assign eng_tog  = tx_act ? ctl.tx_tog : ctl.rx_tog;
  assign cur_stat = tx_act ? ctl.tx_stat : ctl.rx_stat;
  assign txn_done = txn_fire && txn_ok && (cur_stat == ST_VALID);

  // handshake choice for the offered transaction
  always_comb begin
    case (cur_stat)
      ST_STALL: txn_hs = HS_STALL;
      ST_NAK:   txn_hs = HS_NAK;
      ST_VALID: txn_hs = txn_ok ? HS_ACK : HS_NONE;
      default:  txn_hs = HS_NONE;
    endcase
  end

  // next control word: software write, or swap after a completed transaction
  always_comb begin
    nxt      = ctl;
    cand_rx  = ctl.rx_stat ^ wr_mask.rx_stat;
    cand_tx  = ctl.tx_stat ^ wr_mask.tx_stat;
    n_tx_act = 1'b0;
    sw_flip  = 1'b0;
    if (wr_en) begin
      if ((cand_rx == ST_OFF) || (cand_tx == ST_OFF)) begin
        nxt.rx_stat = cand_rx;
        nxt.tx_stat = cand_tx;
      end
      nxt.rx_tog = ctl.rx_tog ^ wr_mask.rx_tog;
      nxt.tx_tog = ctl.tx_tog ^ wr_mask.tx_tog;
      n_tx_act   = (nxt.tx_stat != ST_OFF);
      sw_flip    = n_tx_act ? wr_mask.rx_tog : wr_mask.tx_tog;
      if (sw_flip && (nxt.rx_tog != nxt.tx_tog)) begin
        if (n_tx_act && (nxt.tx_stat == ST_NAK))
          nxt.tx_stat = ST_VALID;
        else if (!n_tx_act && (nxt.rx_stat == ST_NAK))
          nxt.rx_stat = ST_VALID;
      end
    end else if (txn_done) begin
      if (tx_act) begin
        nxt.tx_tog = ~ctl.tx_tog;
        if (~ctl.tx_tog == ctl.rx_tog) nxt.tx_stat = ST_NAK;
      end else begin
        nxt.rx_tog = ~ctl.rx_tog;
        if (~ctl.rx_tog == ctl.tx_tog) nxt.rx_stat = ST_NAK;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl <= '0;
    else        ctl <= nxt;
  end
endmodule

// File: rtl/dbuf_ep_desc.sv
module dbuf_ep_desc
  import dbuf_ep_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sw_we,
  input  logic [DESC_IDX_W-1:0] sw_idx,
  input  logic [DW-1:0]         sw_wdata,
  output logic [DW-1:0]         sw_rdata,
  input  logic                  hw_we,
  input  logic [DESC_IDX_W-1:0] hw_idx,
  input  logic [DW-1:0]         hw_wdata,
  input  logic                  buf_sel,
  output logic [DW-1:0]         buf_addr,
  output logic [DW-1:0]         buf_len
);
  logic [DW-1:0] ent [N_DESC];

  for (genvar i = 0; i < N_DESC; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ent[i] <= '0;
      else if (hw_we && (hw_idx == DESC_IDX_W'(i)))
        ent[i] <= hw_wdata;
      else if (sw_we && (sw_idx == DESC_IDX_W'(i)))
        ent[i] <= sw_wdata;
    end
  end

  assign sw_rdata = ent[sw_idx];
  assign buf_addr = ent[{buf_sel, 1'b0}];
  assign buf_len  = ent[{buf_sel, 1'b1}];
endmodule

// File: rtl/dbuf_ep_hsout.sv
module dbuf_ep_hsout (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] code_in,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [1:0] out_code,
  output logic       slot_free
);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= 2'd0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_code  <= code_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dbuf_ep_ctrl.sv
module dbuf_ep_ctrl
  import dbuf_ep_pkg::*;
#(
  parameter int DESC_W = 16,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              desc_wr_en,
  input  logic [1:0]        desc_idx,
  input  logic [DESC_W-1:0] desc_wdata,
  output logic [DESC_W-1:0] desc_rdata,
  output logic [DESC_W-1:0] buf_addr,
  output logic [DESC_W-1:0] buf_len,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic              evt_ok,
  input  logic [CNT_W-1:0]  evt_count,
  output logic              hs_valid,
  input  logic              hs_ready,
  output logic [1:0]        hs_code
);
  ep_ctl_t    ctl, wr_mask;
  logic       eng_tog, rx_mode, txn_done, slot_free, fire;
  logic [1:0] txn_hs;
  logic       unused_wbits;

  assign wr_mask.rx_tog  = reg_wdata[RX_TOG_BIT];
  assign wr_mask.rx_stat = reg_wdata[RX_STAT_LSB +: 2];
  assign wr_mask.tx_tog  = reg_wdata[TX_TOG_BIT];
  assign wr_mask.tx_stat = reg_wdata[TX_STAT_LSB +: 2];
  assign unused_wbits    = ^{reg_wdata[15], reg_wdata[11:7], reg_wdata[3:0]};

  always_comb begin
    reg_rdata                   = '0;
    reg_rdata[RX_TOG_BIT]       = ctl.rx_tog;
    reg_rdata[RX_STAT_LSB +: 2] = ctl.rx_stat;
    reg_rdata[TX_TOG_BIT]       = ctl.tx_tog;
    reg_rdata[TX_STAT_LSB +: 2] = ctl.tx_stat;
  end

  assign evt_ready = slot_free && !reg_wr_en;
  assign fire      = evt_valid && evt_ready;

  dbuf_ep_ctlreg u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .wr_mask  (wr_mask),
    .txn_fire (fire),
    .txn_ok   (evt_ok),
    .ctl      (ctl),
    .eng_tog  (eng_tog),
    .rx_mode  (rx_mode),
    .txn_hs   (txn_hs),
    .txn_done (txn_done)
  );

  dbuf_ep_desc #(.DW(DESC_W)) u_desc (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_we    (desc_wr_en),
    .sw_idx   (desc_idx),
    .sw_wdata (desc_wdata),
    .sw_rdata (desc_rdata),
    .hw_we    (txn_done && rx_mode),
    .hw_idx   ({eng_tog, 1'b1}),
    .hw_wdata (DESC_W'(evt_count)),
    .buf_sel  (eng_tog),
    .buf_addr (buf_addr),
    .buf_len  (buf_len)
  );

  dbuf_ep_hsout u_hs (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fire),
    .code_in   (txn_hs),
    .out_ready (hs_ready),
    .out_valid (hs_valid),
    .out_code  (hs_code),
    .slot_free (slot_free)
  );
endmodule

// File: rtl/dbuf_ep_ctrl_chk.sv
module dbuf_ep_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr_en,
  input logic [15:0] reg_rdata,
  input logic        evt_valid,
  input logic        evt_ready,
  input logic        evt_ok,
  input logic        hs_valid,
  input logic        hs_ready,
  input logic [1:0]  hs_code
);
  logic       fire;
  logic [1:0] act_stat;
  assign fire     = evt_valid && evt_ready;
  assign act_stat = (reg_rdata[5:4] != 2'b00) ? reg_rdata[5:4] : reg_rdata[13:12];

  a_r2_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[13:12] == 2'b00) || (reg_rdata[5:4] == 2'b00));

  a_r4_fail_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !evt_ok |=> $stable(reg_rdata));

  a_r4_nak_answer: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (act_stat == 2'b10) |=> hs_valid && (hs_code == 2'd2));

  a_r5_swap_flips: assert property (@(posedge clk) disable iff (!rst_n)
    fire && evt_ok && (act_stat == 2'b11)
      |=> (reg_rdata[14] ^ reg_rdata[6]) != $past(reg_rdata[14] ^ reg_rdata[6]));

  a_r9_hold_code: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid && !hs_ready |=> hs_valid && $stable(hs_code));

  a_r9_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> !evt_ready);
endmodule

bind dbuf_ep_ctrl dbuf_ep_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr_en (reg_wr_en),
  .reg_rdata (reg_rdata),
  .evt_valid (evt_valid),
  .evt_ready (evt_ready),
  .evt_ok    (evt_ok),
  .hs_valid  (hs_valid),
  .hs_ready  (hs_ready),
  .hs_code   (hs_code)
);

// File: tb/dbuf_ep_ctrl_test.sv
`timescale 1ns/1ps
module dbuf_ep_ctrl_test;
  localparam int DESC_W = 16;
  localparam int CNT_W  = 10;
  localparam int NV     = 20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr_en = 1'b0;
  logic [15:0]       reg_wdata = '0;
  logic [15:0]       reg_rdata;
  logic              desc_wr_en = 1'b0;
  logic [1:0]        desc_idx = '0;
  logic [DESC_W-1:0] desc_wdata = '0;
  logic [DESC_W-1:0] desc_rdata, buf_addr, buf_len;
  logic              evt_valid = 1'b0;
  logic              evt_ready;
  logic              evt_ok = 1'b0;
  logic [CNT_W-1:0]  evt_count = '0;
  logic              hs_valid;
  logic              hs_ready = 1'b1;
  logic [1:0]        hs_code;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dbuf_ep_ctrl #(.DESC_W(DESC_W), .CNT_W(CNT_W)) uut (.*);

  // {is_event, write data, ok, count, expected handshake, expected control word}
  localparam logic [45:0] VEC [NV] = '{
    {1'b0, 16'h3000, 1'b0, 10'd0,  2'd0, 16'h3000}, // R2 enable rx VALID
    {1'b1, 16'h0000, 1'b1, 10'd64, 2'd1, 16'h7000}, // R5 swap, no collision
    {1'b1, 16'h0000, 1'b1, 10'd32, 2'd1, 16'h2000}, // R5 swap, collision -> NAK
    {1'b1, 16'h0000, 1'b1, 10'd5,  2'd2, 16'h2000}, // R4 NAK answer
    {1'b1, 16'h0000, 1'b0, 10'd5,  2'd2, 16'h2000}, // R4 NAK on failure too
    {1'b0, 16'h0040, 1'b0, 10'd0,  2'd0, 16'h3040}, // R6 release -> VALID
    {1'b1, 16'h0000, 1'b0, 10'd7,  2'd0, 16'h3040}, // R4 failure: no change
    {1'b1, 16'h0000, 1'b1, 10'd16, 2'd1, 16'h6040}, // R5 collision again
    {1'b0, 16'h0000, 1'b0, 10'd0,  2'd0, 16'h6040}, // R3 zero write no effect
    {1'b0, 16'h0040, 1'b0, 10'd0,  2'd0, 16'h7000}, // R6 release again
    {1'b0, 16'h0030, 1'b0, 10'd0,  2'd0, 16'h7000}, // R2 second direction refused
    {1'b0, 16'h1000, 1'b0, 10'd0,  2'd0, 16'h6000}, // R2 VALID->NAK by write
    {1'b0, 16'h3000, 1'b0, 10'd0,  2'd0, 16'h5000}, // R2 NAK->stall
    {1'b1, 16'h0000, 1'b1, 10'd9,  2'd3, 16'h5000}, // R4 stall answer
    {1'b0, 16'h1000, 1'b0, 10'd0,  2'd0, 16'h4000}, // R2 disable
    {1'b1, 16'h0000, 1'b1, 10'd9,  2'd0, 16'h4000}, // R4 disabled: none
    {1'b0, 16'h4030, 1'b0, 10'd0,  2'd0, 16'h0030}, // R2 R3 switch to tx
    {1'b1, 16'h0000, 1'b1, 10'd99, 2'd1, 16'h0070}, // R5 tx swap
    {1'b1, 16'h0000, 1'b1, 10'd98, 2'd1, 16'h0020}, // R5 tx collision
    {1'b0, 16'h4000, 1'b0, 10'd0,  2'd0, 16'h4030}  // R6 tx release
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [15:0] d);
    reg_wr_en = 1'b1; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  task automatic desc_wr(input logic [1:0] i, input logic [DESC_W-1:0] d);
    desc_wr_en = 1'b1; desc_idx = i; desc_wdata = d;
    @(posedge clk); @(negedge clk);
    desc_wr_en = 1'b0;
  endtask

  task automatic send_evt(input logic ok, input logic [CNT_W-1:0] c);
    evt_valid = 1'b1; evt_ok = ok; evt_count = c;
    @(posedge clk); @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctl word", 32'(reg_rdata), 32'h0);
    chk("R1 hs_valid", 32'(hs_valid), 32'h0);
    chk("R1 evt_ready", 32'(evt_ready), 32'h1);
    chk("R1 desc entry", 32'(desc_rdata), 32'h0);

    desc_wr(2'd0, 16'h0100);
    desc_wr(2'd1, 16'h0040);
    desc_wr(2'd2, 16'h0200);
    desc_wr(2'd3, 16'h0040);
    desc_idx = 2'd2;
    #1 chk("R10 desc readback", 32'(desc_rdata), 32'h0200);
    chk("R7 buf0 addr", 32'(buf_addr), 32'h0100);
    chk("R7 buf0 len", 32'(buf_len), 32'h0040);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][45]) begin
        send_evt(VEC[k][28], VEC[k][27:18]);
        chk($sformatf("R4 handshake v%0d", k), 32'(hs_code), 32'(VEC[k][17:16]));
        chk($sformatf("R5 R9 ctl/valid v%0d", k), {15'd0, hs_valid, reg_rdata},
            {15'd0, 1'b1, VEC[k][15:0]});
      end else begin
        reg_wr(VEC[k][44:29]);
        chk($sformatf("R2 R3 R6 ctl word v%0d", k), 32'(reg_rdata), 32'(VEC[k][15:0]));
      end
    end

    // receive wrote 64 then 16 into entry 1 and 32 into entry 3; transmit wrote nothing
    desc_idx = 2'd1;
    #1 chk("R8 rx count buf0 / tx no write", 32'(desc_rdata), 32'd16);
    desc_idx = 2'd3;
    #1 chk("R8 rx count buf1", 32'(desc_rdata), 32'd32);
    @(negedge clk);

    // back-pressure: engine toggle 0, flag 1
    hs_ready = 1'b0;
    send_evt(1'b1, 10'd1);
    chk("R9 held ACK", 32'({hs_valid, hs_code}), 32'({1'b1, 2'd1}));
    chk("R5 tx collision word", 32'(reg_rdata), 32'h4060);
    chk("R7 buf1 addr", 32'(buf_addr), 32'h0200);
    chk("R7 buf1 len", 32'(buf_len), 32'd32);
    evt_valid = 1'b1; evt_ok = 1'b1;
    #1 chk("R9 ready low while held", 32'(evt_ready), 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R9 code stable under stall", 32'({hs_valid, hs_code}), 32'({1'b1, 2'd1}));
    chk("R9 stalled event not taken", 32'(reg_rdata), 32'h4060);
    evt_valid = 1'b0; hs_ready = 1'b1;
    @(negedge clk);
    chk("R9 drained", 32'(hs_valid), 32'h0);

    // a control-word write blocks event acceptance
    reg_wr_en = 1'b1; reg_wdata = 16'h0000; evt_valid = 1'b1;
    #1 chk("R9 write blocks ready", 32'(evt_ready), 32'h0);
    @(posedge clk); @(negedge clk);
    reg_wr_en = 1'b0; evt_valid = 1'b0;
    chk("R9 no response after blocked event", 32'(hs_valid), 32'h0);

    finish_run();
  end
endmodule